// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Guard

This block keeps the status byte of a serial flash device and decides whether each decoded command may run. It holds a busy bit, the write-enable latch, a three-bit block-protect code and a protect bit. The protect bit freezes the nonvolatile bits when the external write-protect pin is asserted. In the one-time-programmable mode the same status bit position shows a lock flag that can be set only once. A command decoder upstream presents one strobe per accepted command, together with the target address and, for a status write, its data byte. The block answers one cycle later with a grant pulse and the updated status.

The array and the program or erase timing live outside this block. When a data-modifying command is granted, the block raises busy and waits for a completion pulse from the array sequencer. That pulse ends the operation and clears the write-enable latch. The nonvolatile bits are held in flops here and come up cleared after reset.

Top module: `flash_sr_guard`

## Requirements
- R1: After reset the status byte reads 0x00, and busy and grant are low.
- R2: A write-enable strobe while not busy sets status bit 1 (write-enable latch) and pulses grant in the next cycle. A write-disable strobe while not busy clears that bit and pulses grant.
- R3: A status write, page program, sector erase, block erase or chip erase issued with the latch clear is refused: no grant, and the status byte is unchanged.
- R4: A granted modifying command sets status bit 0 and busy in the next cycle. A completion pulse while busy clears bit 0, bit 1 and busy in the next cycle. A completion pulse while idle has no effect.
- R5: While busy, every command strobe is refused and leaves the status byte unchanged.
- R6: Block-protect code k in status bits 4:2 makes addresses read-only in a 2^ADDR_W byte array. Code 0 protects nothing. Code 7 protects everything. Codes 1 to 6 protect the top 1/2^(7-k) of the array. The highest byte touched decides: the address itself for a page program, the end of its 4 KB sector for a sector erase, and the end of its 64 KB block for a block erase. Outside the OTP mode, a command that touches protected bytes is refused and keeps the latch set.
- R7: Outside the OTP mode, chip erase is granted only when the block-protect code is 0.
- R8: When the protect bit (status bit 7 outside the OTP mode) is 1 and wp_n is low, a status write is refused and the latch stays set.
- R9: A granted status write outside the OTP mode loads status bits 4:2 from data bits 4:2 and bit 7 from data bit 7. Other data bits are ignored.
- R10: In the OTP mode, status bit 7 shows the lock flag. A granted status write ignores its data, leaves bits 4:2 unchanged and sets the lock. Once the lock is set, further status writes are refused.
- R11: In the OTP mode, program and erase commands are governed only by the lock: granted (given the latch) while the lock is 0, refused once it is 1, whatever the block-protect code.
- R12: Status bits 6:5 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wren | input | 1 | Write-enable command strobe |
| cmd_wrdi | input | 1 | Write-disable command strobe |
| cmd_wrsr | input | 1 | Status write command strobe |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_pp | input | 1 | Page program command strobe |
| cmd_se | input | 1 | Sector erase command strobe |
| cmd_be | input | 1 | Block erase command strobe |
| cmd_ce | input | 1 | Chip erase command strobe |
| op_done | input | 1 | Completion pulse from the array sequencer |
| wp_n | input | 1 | Write-protect pin, active low |
| otp_mode | input | 1 | One-time-programmable mode flag |
| tgt_addr | input | ADDR_W | Target byte address of program or erase |
| status | output | 8 | Status byte |
| grant | output | 1 | One-cycle pulse: previous cycle's command accepted |
| busy | output | 1 | Modifying operation in progress |

## Verification
Every result is due exactly one clock edge after its stimulus: the grant pulse, the status byte and busy are all registered from the cycle in which a strobe or completion pulse is presented. The bench drives inputs on a falling edge, removes them on the next falling edge and samples at that same point. Each check therefore looks at the state one rising edge after the stimulus and before the next one. The block-protect sweep sets every code and tries each command against addresses on both sides of every region boundary. The expected grant comes from the highest touched address compared with the arithmetic region start.

// File: rtl/fsr_pkg.sv
// Shared types for the flash status/write-protect guard.
// Assumes at most one command strobe per cycle from the decoder.
package fsr_pkg;

    // Decoded command kind after priority encoding of the strobes
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_WREN = 3'd1,
        OP_WRDI = 3'd2,
        OP_WRSR = 3'd3,
        OP_PP   = 3'd4,
        OP_SE   = 3'd5,
        OP_BE   = 3'd6,
        OP_CE   = 3'd7
    } fsr_op_e;

    // Control decisions produced by the arbiter for one cycle
    typedef struct packed {
        logic accept;     // command granted
        logic set_wel;    // write-enable accepted
        logic clr_wel;    // write-disable accepted
        logic start_op;   // modifying command starts, busy rises
        logic load_sr;    // status bits load from data byte
        logic set_lock;   // OTP lock set
    } fsr_ctl_t;

    // True for commands that change stored data or status
    function automatic logic is_modify(input fsr_op_e op);
        return (op == OP_WRSR) || (op == OP_PP) || (op == OP_SE) ||
               (op == OP_BE) || (op == OP_CE);
    endfunction

endpackage

// File: rtl/fsr_region_check.sv
// Block-protect region check.
// Finds the highest byte a command touches and reports whether it lies in
// the read-only top fraction chosen by the block-protect code.
// Assumes ADDR_W >= 6 and ADDR_W > BLK_W > SECT_W.
module fsr_region_check
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  fsr_op_e            op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [2:0]         bp_code,
    output logic               hit
);

    localparam int TOP_W = 6;
    localparam logic [ADDR_W-1:0] SECT_MASK = {{(ADDR_W-SECT_W){1'b0}}, {SECT_W{1'b1}}};
    localparam logic [ADDR_W-1:0] BLK_MASK  = {{(ADDR_W-BLK_W){1'b0}}, {BLK_W{1'b1}}};
    localparam logic [TOP_W-1:0]  TOP_ONES  = {TOP_W{1'b1}};

    logic [ADDR_W-1:0] span_end;
    logic [TOP_W-1:0]  top_bits;
    int                frac_w;

    // Highest address touched by the command
    always_comb begin
        unique case (op)
            OP_SE:   span_end = addr | SECT_MASK;
            OP_BE:   span_end = addr | BLK_MASK;
            OP_CE:   span_end = {ADDR_W{1'b1}};
            default: span_end = addr;
        endcase
    end

    // Compare the top address bits with the protected fraction for the code
    always_comb begin
        top_bits = span_end[ADDR_W-1 -: TOP_W];
        frac_w   = 7 - int'(bp_code);
        if (bp_code == 3'd0) begin
            hit = 1'b0;
        end else if (bp_code == 3'd7) begin
            hit = 1'b1;
        end else begin
            hit = ((top_bits >> (TOP_W - frac_w)) == (TOP_ONES >> (TOP_W - frac_w)));
        end
    end

endmodule

// File: rtl/fsr_cmd_arbiter.sv
// Command acceptance logic.
// Decides in one cycle whether the presented command is granted, from the
// busy state, the write-enable latch, hardware/OTP protection and the
// region check, and emits the resulting control strobes.
module fsr_cmd_arbiter
    import fsr_pkg::*;
(
    input  fsr_op_e   op,
    input  logic      busy,
    input  logic      wel,
    input  logic      srp,
    input  logic      otp_lock,
    input  logic      otp_mode,
    input  logic      wp_n,
    input  logic      region_hit,
    output fsr_ctl_t  ctl
);

    logic ok;

    // Grant decision per command kind
    always_comb begin
        unique case (op)
            OP_WREN, OP_WRDI: ok = !busy;
            OP_WRSR:          ok = !busy && wel &&
                                   (otp_mode ? !otp_lock : !(srp && !wp_n));
            OP_PP, OP_SE, OP_BE, OP_CE:
                              ok = !busy && wel &&
                                   (otp_mode ? !otp_lock : !region_hit);
            default:          ok = 1'b0;
        endcase
    end

    // Control strobes derived from the decision
    always_comb begin
        ctl.accept   = ok;
        ctl.set_wel  = ok && (op == OP_WREN);
        ctl.clr_wel  = ok && (op == OP_WRDI);
        ctl.start_op = ok && is_modify(op);
        ctl.load_sr  = ok && (op == OP_WRSR) && !otp_mode;
        ctl.set_lock = ok && (op == OP_WRSR) && otp_mode;
    end

endmodule

// File: rtl/fsr_status_regs.sv
// Status state registers: busy, write-enable latch, block-protect code,
// protect bit, OTP lock and the registered grant pulse.
// Assumes op_done only matters while busy.
module fsr_status_regs
    import fsr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  fsr_ctl_t   ctl,
    input  logic       op_done,
    input  logic [7:0] wr_data,
    output logic       wip_q,
    output logic       wel_q,
    output logic [2:0] bp_q,
    output logic       srp_q,
    output logic       lock_q,
    output logic       grant_q
);

    // Busy flag: rises on a started operation, falls on completion
    always_ff @(posedge clk) begin
        if (!rst_n)             wip_q <= 1'b0;
        else if (ctl.start_op)  wip_q <= 1'b1;
        else if (op_done)       wip_q <= 1'b0;
    end

    // Write-enable latch: set, cleared by disable or by completion
    always_ff @(posedge clk) begin
        if (!rst_n)                 wel_q <= 1'b0;
        else if (ctl.set_wel)       wel_q <= 1'b1;
        else if (ctl.clr_wel)       wel_q <= 1'b0;
        else if (op_done && wip_q)  wel_q <= 1'b0;
    end

    // Nonvolatile protect bits loaded by a status write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_q  <= 3'd0;
            srp_q <= 1'b0;
        end else if (ctl.load_sr) begin
            bp_q  <= wr_data[4:2];
            srp_q <= wr_data[7];
        end
    end

    // One-time lock: can only go from 0 to 1
    always_ff @(posedge clk) begin
        if (!rst_n)            lock_q <= 1'b0;
        else if (ctl.set_lock) lock_q <= 1'b1;
    end

    // Grant pulse one cycle after an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n) grant_q <= 1'b0;
        else        grant_q <= ctl.accept;
    end

endmodule

// File: rtl/flash_sr_guard.sv
// Top of the flash status/write-protect guard.
// Priority-encodes the command strobes, checks protection and keeps the
// status byte. Results appear one clock after the strobe.
// Assumes the decoder presents at most one strobe per cycle.
module flash_sr_guard
    import fsr_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic [7:0]        wrsr_data,
    input  logic              cmd_pp,
    input  logic              cmd_se,
    input  logic              cmd_be,
    input  logic              cmd_ce,
    input  logic              op_done,
    input  logic              wp_n,
    input  logic              otp_mode,
    input  logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        status,
    output logic              grant,
    output logic              busy
);

    fsr_op_e    op;
    fsr_ctl_t   ctl;
    logic       region_hit;
    logic       wip_q, wel_q, srp_q, lock_q, grant_q;
    logic [2:0] bp_q;

    // Priority encode the strobes into one command kind
    always_comb begin
        if (cmd_ce)        op = OP_CE;
        else if (cmd_be)   op = OP_BE;
        else if (cmd_se)   op = OP_SE;
        else if (cmd_pp)   op = OP_PP;
        else if (cmd_wrsr) op = OP_WRSR;
        else if (cmd_wrdi) op = OP_WRDI;
        else if (cmd_wren) op = OP_WREN;
        else               op = OP_NONE;
    end

    fsr_region_check #(
        .ADDR_W (ADDR_W),
        .SECT_W (SECT_W),
        .BLK_W  (BLK_W)
    ) u_region (
        .op      (op),
        .addr    (tgt_addr),
        .bp_code (bp_q),
        .hit     (region_hit)
    );

    fsr_cmd_arbiter u_arb (
        .op         (op),
        .busy       (wip_q),
        .wel        (wel_q),
        .srp        (srp_q),
        .otp_lock   (lock_q),
        .otp_mode   (otp_mode),
        .wp_n       (wp_n),
        .region_hit (region_hit),
        .ctl        (ctl)
    );

    fsr_status_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl     (ctl),
        .op_done (op_done),
        .wr_data (wrsr_data),
        .wip_q   (wip_q),
        .wel_q   (wel_q),
        .bp_q    (bp_q),
        .srp_q   (srp_q),
        .lock_q  (lock_q),
        .grant_q (grant_q)
    );

    // Assemble the status byte; bit 7 follows the mode
    always_comb begin
        status = {(otp_mode ? lock_q : srp_q), 2'b00, bp_q, wel_q, wip_q};
    end

    assign grant = grant_q;
    assign busy  = wip_q;

endmodule

// File: rtl/fsr_guard_checker.sv
// Temporal checks on the guard's ports, attached by bind.
module fsr_guard_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wren,
    input logic       cmd_wrdi,
    input logic       cmd_wrsr,
    input logic       cmd_pp,
    input logic       cmd_se,
    input logic       cmd_be,
    input logic       cmd_ce,
    input logic       op_done,
    input logic       wp_n,
    input logic       otp_mode,
    input logic [7:0] status,
    input logic       grant,
    input logic       busy,
    input logic       lock_q
);

    logic any_mod;
    assign any_mod = cmd_wrsr | cmd_pp | cmd_se | cmd_be | cmd_ce;

    // R2: write-enable while idle sets the latch and grants
    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !cmd_wrdi && !any_mod && !busy) |=> (grant && status[1]));

    // R3: modifying command without the latch is never granted
    a_r3_need_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (any_mod && !cmd_wren && !cmd_wrdi && !status[1]) |=> !grant);

    // R4: completion while busy ends the operation and drops the latch
    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> (!busy && !status[1] && !status[0]));

    // R5: nothing is granted from a busy cycle
    a_r5_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !grant);

    // R8: hardware-protected status write is refused
    a_r8_hpm_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !cmd_pp && !cmd_se && !cmd_be && !cmd_ce &&
         !otp_mode && status[7] && !wp_n) |=> !grant);

    // R10: the lock never clears outside reset
    a_r10_lock_once: assert property (@(posedge clk) disable iff (!rst_n)
        $past(lock_q) |-> lock_q);

    // R12: unused status bits stay zero
    a_r12_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        status[6:5] == 2'b00);

    // R4: busy is mirrored in status bit 0
    a_r4_busy_bit: assert property (@(posedge clk) disable iff (!rst_n)
        busy == status[0]);

endmodule

bind flash_sr_guard fsr_guard_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wren (cmd_wren),
    .cmd_wrdi (cmd_wrdi),
    .cmd_wrsr (cmd_wrsr),
    .cmd_pp   (cmd_pp),
    .cmd_se   (cmd_se),
    .cmd_be   (cmd_be),
    .cmd_ce   (cmd_ce),
    .op_done  (op_done),
    .wp_n     (wp_n),
    .otp_mode (otp_mode),
    .status   (status),
    .grant    (grant),
    .busy     (busy),
    .lock_q   (lock_q)
);

// File: tb/flash_sr_guard_tb.sv
// Self-checking bench: sweeps every block-protect code against addresses
// around each region boundary and walks the protection and OTP sequences.
module flash_sr_guard_tb;
    import fsr_pkg::*;

    localparam int ADDR_W = 21;
    localparam int ASIZE  = 1 << ADDR_W;
    localparam int SMASK  = 32'h0000_0FFF;
    localparam int BMASK  = 32'h0000_FFFF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0;
    logic              cmd_pp = 0, cmd_se = 0, cmd_be = 0, cmd_ce = 0;
    logic [7:0]        wrsr_data = 8'h00;
    logic              op_done = 0, wp_n = 1'b1, otp_mode = 1'b0;
    logic [ADDR_W-1:0] tgt_addr = '0;
    logic [7:0]        status;
    logic              grant, busy;

    int n_vec = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #5 clk = ~clk;

    flash_sr_guard #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
        .wrsr_data(wrsr_data), .cmd_pp(cmd_pp), .cmd_se(cmd_se),
        .cmd_be(cmd_be), .cmd_ce(cmd_ce), .op_done(op_done),
        .wp_n(wp_n), .otp_mode(otp_mode), .tgt_addr(tgt_addr),
        .status(status), .grant(grant), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Present one command for one cycle; sample one edge later
    task automatic issue(input fsr_op_e op, input int addr, input int data);
        @(negedge clk);
        tgt_addr  = addr[ADDR_W-1:0];
        wrsr_data = data[7:0];
        cmd_wren  = (op == OP_WREN);
        cmd_wrdi  = (op == OP_WRDI);
        cmd_wrsr  = (op == OP_WRSR);
        cmd_pp    = (op == OP_PP);
        cmd_se    = (op == OP_SE);
        cmd_be    = (op == OP_BE);
        cmd_ce    = (op == OP_CE);
        @(negedge clk);
        {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_pp, cmd_se, cmd_be, cmd_ce} = '0;
    endtask

    task automatic finish_op();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    // Load block-protect code and protect bit via a full status write
    task automatic set_sr(input int val);
        issue(OP_WREN, 0, 0);
        issue(OP_WRSR, 0, val);
        finish_op();
    endtask

    function automatic bit exp_prot(input int bp, input int span);
        if (bp == 0) return 1'b0;
        if (bp == 7) return 1'b1;
        return span >= (ASIZE - (ASIZE >> (7 - bp)));
    endfunction

    // Try a modifying command with the latch set and check the outcome
    task automatic try_mod(input fsr_op_e op, input int addr, input bit exp_ok,
                           input int base);
        issue(OP_WREN, 0, 0);
        issue(op, addr, 0);
        chk(exp_ok ? "R6 grant" : "R6 refuse", grant, exp_ok);
        if (exp_ok) begin
            chk("R4 busy set", status, base | 8'h03);
            finish_op();
            chk("R4 done clears", status, base);
        end else begin
            chk("R6 latch kept", status, base | 8'h02);
            issue(OP_WRDI, 0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done_flag) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 status", status, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 grant", grant, 0);

        // R3: modifying commands without the latch
        issue(OP_PP, 0, 0);
        chk("R3 pp no grant", grant, 0);
        chk("R3 status", status, 8'h00);
        issue(OP_WRSR, 0, 8'h1C);
        chk("R3 wrsr no grant", grant, 0);
        chk("R3 wrsr status", status, 8'h00);

        // R2: latch set and clear
        issue(OP_WREN, 0, 0);
        chk("R2 wren grant", grant, 1);
        chk("R2 wren status", status, 8'h02);
        issue(OP_WRDI, 0, 0);
        chk("R2 wrdi grant", grant, 1);
        chk("R2 wrdi status", status, 8'h00);

        // R4: completion while idle does nothing
        issue(OP_WREN, 0, 0);
        finish_op();
        chk("R4 idle done", status, 8'h02);
        issue(OP_WRDI, 0, 0);

        // R5: strobes during busy are refused
        issue(OP_WREN, 0, 0);
        issue(OP_PP, 0, 0);
        chk("R4 start", status, 8'h03);
        issue(OP_WRDI, 0, 0);
        chk("R5 wrdi refused", grant, 0);
        chk("R5 status", status, 8'h03);
        issue(OP_WRSR, 0, 8'h9C);
        chk("R5 wrsr refused", grant, 0);
        chk("R5 status2", status, 8'h03);
        issue(OP_SE, 0, 0);
        chk("R5 se refused", grant, 0);
        finish_op();
        chk("R4 done", status, 8'h00);

        // R6/R7/R9: sweep every protect code over the boundaries
        for (int bp = 0; bp < 8; bp++) begin
            set_sr(bp << 2);
            chk("R9 bp load", status, bp << 2);
            for (int f = 1; f <= 6; f++) begin
                for (int d = 0; d < 2; d++) begin
                    int a;
                    a = ASIZE - (ASIZE >> f) - d;
                    try_mod(OP_PP, a, !exp_prot(bp, a), bp << 2);
                    try_mod(OP_SE, a, !exp_prot(bp, a | SMASK), bp << 2);
                    try_mod(OP_BE, a, !exp_prot(bp, a | BMASK), bp << 2);
                end
            end
            try_mod(OP_PP, 0, !exp_prot(bp, 0), bp << 2);
            try_mod(OP_PP, ASIZE - 1, !exp_prot(bp, ASIZE - 1), bp << 2);
            // R7: chip erase only with code 0
            try_mod(OP_CE, 0, (bp == 0), bp << 2);
        end

        // R9/R12: data bits outside the fields are ignored
        set_sr(8'hFF);
        chk("R9 masked load", status, 8'h9C);
        chk("R12 zero bits", status[6:5], 0);

        // R8: hardware protection blocks status write
        wp_n = 1'b0;
        issue(OP_WREN, 0, 0);
        issue(OP_WRSR, 0, 8'h00);
        chk("R8 refused", grant, 0);
        chk("R8 status kept", status, 8'h9E);
        wp_n = 1'b1;
        issue(OP_WRSR, 0, 8'h00);
        chk("R8 released grant", grant, 1);
        chk("R8 released status", status, 8'h03);
        finish_op();
        chk("R8 after done", status, 8'h00);

        // R10/R11: OTP mode
        set_sr(8'h0C);
        otp_mode = 1'b1;
        @(negedge clk);
        chk("R10 lock shown clear", status, 8'h0C);
        try_mod(OP_PP, ASIZE - 1, 1'b1, 8'h0C);   // R11 bp ignored
        try_mod(OP_CE, 0, 1'b1, 8'h0C);            // R11
        issue(OP_WREN, 0, 0);
        issue(OP_WRSR, 0, 8'h00);
        chk("R10 lock grant", grant, 1);
        chk("R10 lock status", status, 8'h8F);
        finish_op();
        chk("R10 data ignored", status, 8'h8C);
        issue(OP_WREN, 0, 0);
        issue(OP_WRSR, 0, 8'h00);
        chk("R10 second refused", grant, 0);
        chk("R10 status", status, 8'h8E);
        issue(OP_PP, 0, 0);
        chk("R11 pp locked", grant, 0);
        issue(OP_BE, 0, 0);
        chk("R11 be locked", grant, 0);
        chk("R11 status", status, 8'h8E);
        otp_mode = 1'b0;
        @(negedge clk);
        chk("R10 bit7 follows mode", status, 8'h0E);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule